// File: doc/BRIEF.md
# Block Transfer Read/Write Buffer

This block sits between a subsystem processor port and a shared main RAM. It holds a 32-word copy of one subaddress data block. The processor keeps using the same addresses it would use for the main RAM. The block decides whether each access is served from its own word store or passed through to the RAM arbiter.

On the first buffered read of a block, the block claims the RAM and copies all 32 words of that subaddress in one atomic burst. The processor is stalled until the burst ends. Later reads of the block come from the snapshot, so the data stays consistent even if the RAM changes or the bus-side DMA owns it. Reads go from offset n-1 down to offset 0, and a read of offset 0 re-arms the sequencer. Buffered writes follow the same descending order and collect in the store. The offset-0 write commits offsets 0..n-1 to the RAM as a single burst, where n is one more than the first written offset. Read and write buffering are switched on and off separately by writes to four decoded control addresses.

The controller is one state machine with these states:
- IDLE: no block open.
- FETCH_ACQ: waits for the RAM grant before a fetch.
- FETCH: runs the read burst.
- RD_SERVE: a fetched block is open for reads.
- WR_FILL: a write block is collecting words.
- COMMIT_ACQ: waits for the RAM grant before a commit.
- COMMIT: runs the write burst.
- PASS: a granted direct RAM access.
- PASS_RD: captures the data of a direct RAM read.

Transitions:
- IDLE goes to FETCH_ACQ, WR_FILL, COMMIT_ACQ or PASS.
- FETCH_ACQ goes to FETCH on grant.
- FETCH goes to RD_SERVE on the last beat.
- RD_SERVE goes to IDLE on an offset-0 read, or to PASS.
- WR_FILL goes to COMMIT_ACQ on an offset-0 write, or to PASS.
- COMMIT_ACQ goes to COMMIT on grant.
- COMMIT goes to IDLE on the last beat.
- PASS goes to PASS_RD for a read, or back to the state it came from for a write.
- PASS_RD goes back to the state PASS came from.

Top module: `btl_xfer_buffer`

## Requirements
- R1: After reset, cpu_ack, ram_req and ram_en are low, and both read and write buffering are enabled.
- R2: A buffered read while no block is open copies all 32 words of the addressed subaddress from RAM. cpu_ack stays low until the copy ends, and the read then returns the word at the requested offset.
- R3: During a burst, RAM accesses are issued once every WORD_CYC (4) cycles. They go to offsets 0, 1, 2 … of the latched subaddress in ascending order.
- R4: While a fetched block is open, buffered reads are acknowledged one cycle after the request with no RAM access, even when the RAM grant is withheld. They return the snapshot even if the RAM word has since changed.
- R5: A buffered read of offset 0 closes the block, and the next buffered read starts a new 32-word fetch that sees the current RAM contents.
- R6: A burst starts only after ram_gnt is seen. Until then the processor stays stalled and no RAM access occurs. Once started, a burst runs every beat without leaving its state.
- R7: Control writes are acknowledged without any RAM access, using these addresses:
    - 0x402 disables both read and write buffering.
    - 0x403 enables write buffering only.
    - 0x404 enables read buffering only.
    - 0x405 enables both.

  In other words, address bit 0 selects write buffering and bit 1 of (address − 0x402) selects read buffering.
- R8: The buffered area is addresses with bits [11:10] = 0, subaddress in bits [9:5] and offset in bits [4:0]. Subaddress 0 is never buffered. Subaddress 31 is buffered only when alt_sa31_data is high. Every other access goes to the RAM as a single access.
- R9: A read while read buffering is disabled, or a write while write buffering is disabled, passes through as a single RAM access at the processor address.
- R10: Buffered writes to non-zero offsets are acknowledged one cycle after the request with no RAM access. The offset-0 write commits offsets 0..n-1 as WORD_CYC-spaced RAM writes, where n is the first written offset plus one, and is acknowledged after the commit.
- R11: A pass-through access waits for ram_gnt. A pass-through read returns the RAM word read by its single access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alt_sa31_data | input | 1 | Treat subaddress 31 as a buffered data area |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_addr | input | 12 | Processor word address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_ack | output | 1 | One-cycle acknowledge |
| cpu_rdata | output | 16 | Read data, valid with cpu_ack |
| ram_req | output | 1 | RAM ownership request, held for a whole burst |
| ram_gnt | input | 1 | Arbiter grant |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write (1) or read (0) |
| ram_addr | output | 12 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, one cycle after a read strobe |

## Verification
The checker watches several rules on every cycle:
- a RAM strobe only ever appears with ownership and grant;
- fetch and commit bursts leave their state only toward the block-open or idle state;
- strobes inside a burst are never back to back;
- the processor is never acknowledged while a fetch is pending;
- every acknowledge is a single-cycle pulse.

Other behaviours need the bench's scenarios:
- that a burst copies exactly the right 32 addresses at 4-cycle spacing;
- that the snapshot survives a RAM change;
- that an offset-0 read re-arms the fetch;
- the control-address encoding;
- the excluded subaddresses;
- the contents committed by a write block.

// File: rtl/btl_pkg.sv
package btl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH_ACQ,
        ST_FETCH,
        ST_RD_SERVE,
        ST_WR_FILL,
        ST_COMMIT_ACQ,
        ST_COMMIT,
        ST_PASS,
        ST_PASS_RD
    } btl_state_e;

    typedef enum logic [1:0] {
        AC_CTRL,
        AC_BUF_RD,
        AC_BUF_WR,
        AC_PASS
    } acc_kind_e;

    typedef enum logic [1:0] {
        RS_NONE,
        RS_BUF,
        RS_RAM
    } rsel_e;

endpackage

// File: rtl/btl_classify.sv
module btl_classify
    import btl_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int SA_W    = 5,
    parameter int OFF_W   = 5,
    parameter int CTRL_LO = 'h402
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              alt_sa31,
    output acc_kind_e         kind,
    output logic              ctrl_rd,
    output logic              ctrl_wr
);
    localparam int SA_LO = OFF_W;
    localparam int SA_HI = OFF_W + SA_W - 1;

    logic [SA_W-1:0]   sa;
    logic [ADDR_W-1:0] rel;
    logic              in_area;
    logic              is_ctrl;

    assign sa      = addr[SA_HI:SA_LO];
    assign rel     = addr - ADDR_W'(CTRL_LO);
    assign is_ctrl = we && (addr >= ADDR_W'(CTRL_LO)) && (rel <= ADDR_W'(3));
    assign in_area = (addr[ADDR_W-1:SA_HI+1] == '0) && (sa != '0) &&
                     ((sa != '1) || alt_sa31);
    assign ctrl_wr = rel[0];
    assign ctrl_rd = rel[1];

    always_comb begin
        if (is_ctrl)                   kind = AC_CTRL;
        else if (in_area && !we && rd_en) kind = AC_BUF_RD;
        else if (in_area && we && wr_en)  kind = AC_BUF_WR;
        else                           kind = AC_PASS;
    end
endmodule

// File: rtl/btl_buffer.sv
module btl_buffer #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 16,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) words[waddr] <= wdata;
    end

    assign rdata_a = words[raddr_a];
    assign rdata_b = words[raddr_b];
endmodule

// File: rtl/btl_burst_timer.sv
module btl_burst_timer #(
    parameter int OFF_W    = 5,
    parameter int WORD_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [OFF_W:0]   len,
    output logic [OFF_W-1:0] beat,
    output logic             issue,
    output logic             land,
    output logic             last
);
    localparam int PH_W = $clog2(WORD_CYC);
    localparam logic [PH_W-1:0] PH_END = PH_W'(WORD_CYC - 1);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat  <= '0;
            phase <= '0;
        end else if (start) begin
            beat  <= '0;
            phase <= '0;
        end else if (run) begin
            if (phase == PH_END) begin
                phase <= '0;
                beat  <= beat + 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    assign issue = run && (phase == '0);
    assign land  = run && (phase == PH_W'(1));
    assign last  = run && (phase == PH_END) && ({1'b0, beat} == len - 1'b1);
endmodule

// File: rtl/btl_xfer_buffer.sv
module btl_xfer_buffer
    import btl_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 16,
    parameter int SA_W     = 5,
    parameter int OFF_W    = 5,
    parameter int WORD_CYC = 4,
    parameter int CTRL_LO  = 'h402
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alt_sa31_data,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              ram_req,
    input  logic              ram_gnt,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);
    localparam int DEPTH = 1 << OFF_W;
    localparam int SA_LO = OFF_W;
    localparam int SA_HI = OFF_W + SA_W - 1;

    btl_state_e        state, nxt, ret_q;
    logic [SA_W-1:0]   sa_q;
    logic [OFF_W:0]    cnt_q, burst_len;
    logic              rd_en_q, wr_en_q, ack_q;
    logic [DATA_W-1:0] rdata_q;

    acc_kind_e         kind;
    logic              ctrl_rd, ctrl_wr, req_hit;
    logic [OFF_W-1:0]  off, beat;
    logic              issue, land, last, t_start, t_run;
    logic              ack_set, ctrl_upd, grab, ret_set, cpu_buf_wr;
    rsel_e             rsel;
    logic              buf_we;
    logic [OFF_W-1:0]  buf_waddr;
    logic [DATA_W-1:0] buf_wdata, buf_rd_a, buf_rd_b;
    logic [ADDR_W-1:0] burst_addr;

    assign off     = cpu_addr[OFF_W-1:0];
    assign req_hit = cpu_req && !ack_q;

    btl_classify #(.ADDR_W(ADDR_W), .SA_W(SA_W), .OFF_W(OFF_W), .CTRL_LO(CTRL_LO)) u_cls (
        .we(cpu_we), .addr(cpu_addr), .rd_en(rd_en_q), .wr_en(wr_en_q),
        .alt_sa31(alt_sa31_data), .kind(kind), .ctrl_rd(ctrl_rd), .ctrl_wr(ctrl_wr)
    );

    assign t_start   = ((state == ST_FETCH_ACQ) || (state == ST_COMMIT_ACQ)) && ram_gnt;
    assign t_run     = (state == ST_FETCH) || (state == ST_COMMIT);
    assign burst_len = (state == ST_COMMIT) ? cnt_q : (OFF_W+1)'(DEPTH);

    btl_burst_timer #(.OFF_W(OFF_W), .WORD_CYC(WORD_CYC)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(t_start), .run(t_run), .len(burst_len),
        .beat(beat), .issue(issue), .land(land), .last(last)
    );

    btl_buffer #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(OFF_W)) u_buf (
        .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
        .raddr_a(off), .rdata_a(buf_rd_a), .raddr_b(beat), .rdata_b(buf_rd_b)
    );

    // Next state and per-cycle decisions.
    always_comb begin
        nxt        = state;
        ack_set    = 1'b0;
        ctrl_upd   = 1'b0;
        grab       = 1'b0;
        ret_set    = 1'b0;
        cpu_buf_wr = 1'b0;
        rsel       = RS_NONE;
        unique case (state)
            ST_IDLE, ST_RD_SERVE, ST_WR_FILL: begin
                if (req_hit) begin
                    unique case (kind)
                        AC_CTRL: begin
                            ack_set  = 1'b1;
                            ctrl_upd = 1'b1;
                        end
                        AC_BUF_RD: begin
                            if (state == ST_RD_SERVE) begin
                                ack_set = 1'b1;
                                rsel    = RS_BUF;
                                if (off == '0) nxt = ST_IDLE;
                            end else if (state == ST_IDLE) begin
                                grab = 1'b1;
                                nxt  = ST_FETCH_ACQ;
                            end else begin
                                ret_set = 1'b1;
                                nxt     = ST_PASS;
                            end
                        end
                        AC_BUF_WR: begin
                            if (state == ST_RD_SERVE) begin
                                ret_set = 1'b1;
                                nxt     = ST_PASS;
                            end else begin
                                grab       = (state == ST_IDLE);
                                cpu_buf_wr = 1'b1;
                                if (off == '0) nxt = ST_COMMIT_ACQ;
                                else begin
                                    ack_set = 1'b1;
                                    nxt     = ST_WR_FILL;
                                end
                            end
                        end
                        default: begin
                            ret_set = 1'b1;
                            nxt     = ST_PASS;
                        end
                    endcase
                end
            end
            ST_FETCH_ACQ:  if (ram_gnt) nxt = ST_FETCH;
            ST_FETCH:      if (last) nxt = ST_RD_SERVE;
            ST_COMMIT_ACQ: if (ram_gnt) nxt = ST_COMMIT;
            ST_COMMIT: begin
                if (last) begin
                    ack_set = 1'b1;
                    nxt     = ST_IDLE;
                end
            end
            ST_PASS: begin
                if (ram_gnt) begin
                    if (cpu_we) begin
                        ack_set = 1'b1;
                        nxt     = ret_q;
                    end else begin
                        nxt = ST_PASS_RD;
                    end
                end
            end
            ST_PASS_RD: begin
                ack_set = 1'b1;
                rsel    = RS_RAM;
                nxt     = ret_q;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register and held context.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ret_q   <= ST_IDLE;
            sa_q    <= '0;
            cnt_q   <= '0;
            rd_en_q <= 1'b1;
            wr_en_q <= 1'b1;
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            state <= nxt;
            ack_q <= ack_set;
            if (ret_set) ret_q <= state;
            if (grab) begin
                sa_q  <= cpu_addr[SA_HI:SA_LO];
                cnt_q <= {1'b0, off} + 1'b1;
            end
            if (ctrl_upd) begin
                rd_en_q <= ctrl_rd;
                wr_en_q <= ctrl_wr;
            end
            if (rsel == RS_BUF)      rdata_q <= buf_rd_a;
            else if (rsel == RS_RAM) rdata_q <= ram_rdata;
        end
    end

    always_comb begin
        burst_addr = '0;
        burst_addr[SA_HI:SA_LO] = sa_q;
        burst_addr[OFF_W-1:0]   = beat;
    end

    // Outputs toward RAM and the word store.
    always_comb begin
        ram_req   = 1'b0;
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = burst_addr;
        ram_wdata = buf_rd_b;
        buf_we    = cpu_buf_wr;
        buf_waddr = off;
        buf_wdata = cpu_wdata;
        unique case (state)
            ST_FETCH_ACQ, ST_COMMIT_ACQ: ram_req = 1'b1;
            ST_FETCH: begin
                ram_req = 1'b1;
                ram_en  = issue;
                if (land) begin
                    buf_we    = 1'b1;
                    buf_waddr = beat;
                    buf_wdata = ram_rdata;
                end
            end
            ST_COMMIT: begin
                ram_req = 1'b1;
                ram_en  = issue;
                ram_we  = 1'b1;
            end
            ST_PASS: begin
                ram_req   = 1'b1;
                ram_en    = ram_gnt;
                ram_we    = cpu_we;
                ram_addr  = cpu_addr;
                ram_wdata = cpu_wdata;
            end
            default: ;
        endcase
    end

    assign cpu_ack   = ack_q;
    assign cpu_rdata = rdata_q;
endmodule

// File: rtl/btl_xfer_buffer_chk.sv
module btl_xfer_buffer_chk
    import btl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input btl_state_e st,
    input logic       ram_req,
    input logic       ram_gnt,
    input logic       ram_en,
    input logic       ram_we,
    input logic       cpu_ack
);
    assert_en_granted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> (ram_req && ram_gnt));

    assert_fetch_atomic_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FETCH) |=> (st == ST_FETCH || st == ST_RD_SERVE));

    assert_commit_atomic_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COMMIT) |=> (st == ST_COMMIT || st == ST_IDLE));

    assert_no_ack_in_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FETCH_ACQ || st == ST_FETCH) |-> !cpu_ack);

    assert_burst_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && (st == ST_FETCH || st == ST_COMMIT)) |=> !ram_en);

    assert_fetch_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && st == ST_FETCH) |-> !ram_we);

    assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);
endmodule

bind btl_xfer_buffer btl_xfer_buffer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .st(state), .ram_req(ram_req), .ram_gnt(ram_gnt),
    .ram_en(ram_en), .ram_we(ram_we), .cpu_ack(cpu_ack)
);

// File: tb/sim_btl_xfer_buffer.sv
module sim_btl_xfer_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alt_sa31_data = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [11:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_ack;
    logic [15:0] cpu_rdata;
    logic        ram_req, ram_en, ram_we;
    logic        ram_gnt = 1'b0;
    logic [11:0] ram_addr;
    logic [15:0] ram_wdata;
    logic [15:0] ram_rdata = '0;
    logic        dma_busy = 1'b0;
    logic        dma_auto = 1'b0;

    int total = 0, bad = 0, cyc = 0, log_n = 0, mk = 0;
    bit finished = 0;
    logic [15:0] mem [0:4095];
    logic [11:0] log_a [0:255];
    int          log_c [0:255];
    logic        log_w [0:255];

    always #5 clk = ~clk;

    btl_xfer_buffer u0 (
        .clk(clk), .rst_n(rst_n), .alt_sa31_data(alt_sa31_data),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .ram_req(ram_req), .ram_gnt(ram_gnt), .ram_en(ram_en), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // RAM model, arbiter model and access log.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ram_en) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            else        ram_rdata <= mem[ram_addr];
            log_a[log_n % 256] <= ram_addr;
            log_c[log_n % 256] <= cyc;
            log_w[log_n % 256] <= ram_we;
            log_n <= log_n + 1;
        end
        if (!rst_n || !ram_req) ram_gnt <= 1'b0;
        else if (!dma_busy)     ram_gnt <= 1'b1;
    end

    function automatic logic [11:0] A(input int sa, input int off);
        return {2'b00, 5'(sa), 5'(off)};
    endfunction

    function automatic logic [15:0] init_val(input int a);
        return 16'((a * 32'h3a7) ^ 32'h5c00);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [11:0] a, input logic [15:0] wd,
                          output logic [15:0] rd, output int waited);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!cpu_ack && waited < 3000);
        rd = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    task automatic mark();
        mk = log_n;
    endtask

    task automatic check_burst(input string tag, input logic [11:0] base, input int n, input bit we);
        bit ok = (log_n - mk == n);
        for (int i = 0; i < n && ok; i++) begin
            if (log_a[(mk + i) % 256] != base + 12'(i)) ok = 0;
            if (log_w[(mk + i) % 256] != we) ok = 0;
            if (i > 0 && log_c[(mk + i) % 256] - log_c[(mk + i - 1) % 256] != 4) ok = 0;
        end
        chk(ok, tag, log_n - mk, n);
    endtask

    initial begin : dma_noise
        forever begin
            @(negedge clk);
            if (dma_auto && ($urandom % 16 == 0)) dma_busy = ~dma_busy;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] rd, old6, e [32], v [32];
        int w;
        void'($urandom(32'd1234));
        for (int i = 0; i < 4096; i++) mem[i] = init_val(i);
        repeat (4) @(negedge clk);
        chk(!cpu_ack && !ram_req && !ram_en, "R1 reset outputs", {cpu_ack, ram_req, ram_en}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2/R3: first read fetches the whole block
        old6 = mem[A(5, 6)];
        mark();
        access(0, A(5, 7), 0, rd, w);
        chk(rd == init_val(A(5, 7)), "R2 first read data", rd, init_val(A(5, 7)));
        chk(w >= 128, "R2 stall through fetch", w, 128);
        check_burst("R3 fetch burst", A(5, 0), 32, 0);

        // R4: snapshot served with no RAM, even without grant
        mem[A(5, 6)] = ~old6;
        dma_busy = 1'b1;
        mark();
        access(0, A(5, 6), 0, rd, w);
        chk(rd == old6, "R4 snapshot data", rd, old6);
        chk(w == 1 && log_n == mk, "R4 no delay no RAM", w, 1);
        dma_busy = 1'b0;
        for (int o = 5; o >= 0; o--) begin
            access(0, A(5, o), 0, rd, w);
            chk(rd == init_val(A(5, o)), "R4 descending reads", rd, init_val(A(5, o)));
        end
        // R5: offset 0 re-armed; new fetch sees current RAM
        mark();
        access(0, A(5, 6), 0, rd, w);
        chk(rd == ~old6, "R5 refetch sees new data", rd, ~old6);
        chk(log_n - mk == 32, "R5 refetch burst", log_n - mk, 32);
        access(0, A(5, 0), 0, rd, w);

        // R6: burst waits for grant
        dma_busy = 1'b1;
        mark();
        fork
            access(0, A(7, 3), 0, rd, w);
            begin
                repeat (40) @(negedge clk);
                chk(log_n == mk && !cpu_ack, "R6 wait for grant", log_n - mk, 0);
                dma_busy = 1'b0;
            end
        join
        chk(rd == init_val(A(7, 3)), "R6 data after grant", rd, init_val(A(7, 3)));
        check_burst("R6 burst after grant", A(7, 0), 32, 0);
        access(0, A(7, 0), 0, rd, w);

        // R7/R9: control encodings
        mark();
        access(1, 12'h404, 0, rd, w);
        chk(log_n == mk, "R7 ctrl no RAM", log_n - mk, 0);
        access(1, A(3, 2), 16'h1234, rd, w);
        chk(log_n - mk == 1 && mem[A(3, 2)] == 16'h1234, "R9 write passes when disabled", mem[A(3, 2)], 16'h1234);
        mark();
        access(0, A(3, 2), 0, rd, w);
        chk(log_n - mk == 32 && rd == 16'h1234, "R7 0x404 keeps read buffering", log_n - mk, 32);
        access(0, A(3, 0), 0, rd, w);
        access(1, 12'h403, 0, rd, w);
        mark();
        access(0, A(9, 4), 0, rd, w);
        chk(log_n - mk == 1, "R9 read passes when disabled", log_n - mk, 1);
        chk(rd == init_val(A(9, 4)), "R11 pass read data", rd, init_val(A(9, 4)));
        access(1, 12'h402, 0, rd, w);
        mark();
        access(1, A(9, 1), 16'h0bad, rd, w);
        chk(log_n - mk == 1 && mem[A(9, 1)] == 16'h0bad, "R7 0x402 disables writes", log_n - mk, 1);
        access(1, 12'h405, 0, rd, w);

        // R10: write block commit
        mark();
        for (int o = 3; o >= 1; o--) begin
            access(1, A(12, o), 16'ha000 + 16'(o), rd, w);
            chk(w == 1, "R10 buffered write ack", w, 1);
        end
        chk(log_n == mk, "R10 no RAM before commit", log_n - mk, 0);
        access(1, A(12, 0), 16'ha000, rd, w);
        check_burst("R10 commit burst", A(12, 0), 4, 1);
        for (int o = 0; o < 4; o++)
            chk(mem[A(12, o)] == 16'ha000 + 16'(o), "R10 committed data", mem[A(12, o)], 16'ha000 + 16'(o));
        chk(mem[A(12, 4)] == init_val(A(12, 4)), "R10 untouched word", mem[A(12, 4)], init_val(A(12, 4)));

        // R8: excluded areas
        mark();
        access(0, A(0, 3), 0, rd, w);
        chk(log_n - mk == 1 && rd == init_val(A(0, 3)), "R8 subaddress 0 passes", log_n - mk, 1);
        mark();
        access(0, A(31, 2), 0, rd, w);
        chk(log_n - mk == 1, "R8 subaddress 31 passes", log_n - mk, 1);
        alt_sa31_data = 1'b1;
        mark();
        access(0, A(31, 2), 0, rd, w);
        chk(log_n - mk == 32 && rd == init_val(A(31, 2)), "R8 subaddress 31 buffered in alt mode", log_n - mk, 32);
        access(0, A(31, 0), 0, rd, w);
        alt_sa31_data = 1'b0;
        mark();
        access(0, 12'h823, 0, rd, w);
        chk(log_n - mk == 1 && rd == init_val(12'h823), "R8 R11 other region passes", rd, init_val(12'h823));

        // Random block sequences with arbitration noise
        dma_auto = 1'b1;
        for (int it = 0; it < 40; it++) begin
            int sa = 1 + int'($urandom % 30);
            int n  = 1 + int'($urandom % 32);
            if ($urandom % 2 == 0) begin
                for (int o = 0; o < 32; o++) e[o] = mem[A(sa, o)];
                for (int o = n - 1; o >= 0; o--) begin
                    access(0, A(sa, o), 0, rd, w);
                    chk(rd == e[o], "R2 R5 random read", rd, e[o]);
                end
            end else begin
                for (int o = 0; o < 32; o++) v[o] = 16'($urandom);
                for (int o = n - 1; o >= 0; o--) access(1, A(sa, o), v[o], rd, w);
                for (int o = 0; o < n; o++)
                    chk(mem[A(sa, o)] == v[o], "R10 random commit", mem[A(sa, o)], v[o]);
            end
        end
        dma_auto = 1'b0;
        dma_busy = 1'b0;

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule